// File: doc/BRIEF.md
# Power Reset Generator with Glitch Filter

This block generates a single long, active-high power reset pulse once an asynchronous power-up condition releases. The pulse width is counted on a free-running internal clock. The pulse does not reset anything directly. It leaves on `pulse_out` and has to come back on `loop_in` through a connection on the board. Leaving that connection open inhibits power reset. The board is assumed to hold an open `loop_in` pad low with a pull-down, so the open loop reads as deasserted.

The returning signal first passes a two-stage synchronizer and then a qualifying filter. The filter asserts `chip_rst` only after the input has stayed high for more clock samples than any glitch of `GLITCH_PS` picoseconds could produce. `chip_rst` releases synchronously to the clock. It drives the chip's reset tree.

Two state machines do the work:
- The generator moves from ARMED to PULSE on the first clock after power-up release. It moves from PULSE to DONE when its count expires. DONE is left only by a new power-up reset.
- The filter moves from IDLE to QUAL on a high sample, back from QUAL to IDLE on a low sample, and from QUAL to ACTIVE when the qualifying count is reached. It moves from ACTIVE to IDLE on the first low sample.

Top module: `prst_top`

## Requirements
- R1: While `por_n` is low, `pulse_out` and `chip_rst` are 0, and they clear at once (asynchronously) when `por_n` falls.
- R2: `pulse_out` rises after the first rising clock edge following the release of `por_n`. It stays high for exactly PULSE_CYCLES = PULSE_NS*1000/CLK_PERIOD_PS clock cycles.
- R3: After the pulse ends, `pulse_out` stays low until the next low phase of `por_n`.
- R4: `loop_in` is sampled through a 2-flop synchronizer. If `loop_in` is first sampled high at edge A and stays high, `chip_rst` is high from edge A+1+FILT onward, where FILT = GLITCH_PS/CLK_PERIOD_PS + 2 (integer division).
- R5: If `loop_in` is first sampled low at edge B while `chip_rst` is high, `chip_rst` goes low after edge B+2, synchronously to the clock.
- R6: A high stretch on `loop_in` that spans fewer than FILT sampling edges never raises `chip_rst`. This covers every pulse up to GLITCH_PS wide.
- R7: A high stretch spanning k >= FILT sampling edges holds `chip_rst` high for exactly k-FILT+1 cycles.
- R8: With the loop open (`loop_in` held low), `pulse_out` still pulses but `chip_rst` stays 0.
- R9: A new low phase of `por_n`, even one that cuts a running pulse, re-arms the generator, and a full-width pulse follows the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| por_n | input | 1 | Asynchronous power-up condition, active low |
| loop_in | input | 1 | Returning power reset from the external loop |
| pulse_out | output | 1 | Generated power reset pulse, active high |
| chip_rst | output | 1 | Filtered reset to the chip's reset tree, active high |

## Verification
The filter is driven with clock-aligned high stretches from one sample up to several times FILT. This separates rejected glitches (zero width) from qualified resets, and the exact output width shows whether the qualifying count is off by one. The generator is exercised with the loop shorted, which checks pulse width, filter latency and the relation between the two widths. It is also run with the loop open, which separates generation from the inhibit, and with a power-up drop in mid-pulse, which shows asynchronous clearing and re-arming. A long idle watch after the pulse catches any retrigger.

// File: rtl/prst_pkg.sv
package prst_pkg;

    typedef enum logic [1:0] {
        GEN_ARMED = 2'd0,
        GEN_PULSE = 2'd1,
        GEN_DONE  = 2'd2
    } gen_state_t;

    typedef enum logic [1:0] {
        FLT_IDLE   = 2'd0,
        FLT_QUAL   = 2'd1,
        FLT_ACTIVE = 2'd2
    } flt_state_t;

endpackage

// File: rtl/prst_pulse_gen.sv
module prst_pulse_gen
    import prst_pkg::*;
#(
    parameter int PULSE_CYCLES = 50000
) (
    input  logic clk,
    input  logic por_n,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    gen_state_t    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= GEN_ARMED;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            GEN_ARMED: begin
                state_nxt = GEN_PULSE;
                cnt_nxt   = '0;
            end
            GEN_PULSE: begin
                if (cnt == LAST) begin
                    state_nxt = GEN_DONE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            GEN_DONE: begin
                state_nxt = GEN_DONE;
            end
            default: begin
                state_nxt = GEN_DONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        pulse_o = (state == GEN_PULSE);
    end

endmodule

// File: rtl/prst_sync.sv
module prst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/prst_glitch_filt.sv
module prst_glitch_filt
    import prst_pkg::*;
#(
    parameter int FILT_CYCLES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic s_i,
    output logic rst_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] GOAL = CW'(FILT_CYCLES);

    flt_state_t    state, state_nxt;
    logic [CW-1:0] run, run_nxt;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= FLT_IDLE;
            run   <= '0;
        end else begin
            state <= state_nxt;
            run   <= run_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        run_nxt   = run;
        unique case (state)
            FLT_IDLE: begin
                if (s_i) begin
                    state_nxt = FLT_QUAL;
                    run_nxt   = CW'(1);
                end
            end
            FLT_QUAL: begin
                if (!s_i) begin
                    state_nxt = FLT_IDLE;
                    run_nxt   = '0;
                end else if (run + 1'b1 >= GOAL) begin
                    state_nxt = FLT_ACTIVE;
                    run_nxt   = '0;
                end else begin
                    run_nxt = run + 1'b1;
                end
            end
            FLT_ACTIVE: begin
                if (!s_i) begin
                    state_nxt = FLT_IDLE;
                end
            end
            default: begin
                state_nxt = FLT_IDLE;
                run_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_o = (state == FLT_ACTIVE);
    end

endmodule

// File: rtl/prst_top.sv
module prst_top #(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int PULSE_NS      = 1000000,
    parameter int GLITCH_PS     = 8000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic loop_in,
    output logic pulse_out,
    output logic chip_rst
);
    localparam int PULSE_CYCLES = (PULSE_NS * 1000) / CLK_PERIOD_PS;
    localparam int FILT_CYCLES  = GLITCH_PS / CLK_PERIOD_PS + 2;

    logic loop_sync;

    prst_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_gen (
        .clk    (clk),
        .por_n  (por_n),
        .pulse_o(pulse_out)
    );

    prst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .por_n(por_n),
        .d_i  (loop_in),
        .q_o  (loop_sync)
    );

    prst_glitch_filt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk  (clk),
        .por_n(por_n),
        .s_i  (loop_sync),
        .rst_o(chip_rst)
    );

endmodule

// File: rtl/prst_chk.sv
module prst_chk #(
    parameter int FILT_CYCLES  = 2,
    parameter int PULSE_CYCLES = 50000
) (
    input logic clk,
    input logic por_n,
    input logic pulse_out,
    input logic chip_rst,
    input logic loop_sync
);
    localparam int PW = $clog2(PULSE_CYCLES + 2);
    localparam int FW = $clog2(FILT_CYCLES + 2);

    logic [PW-1:0] width_cnt;
    logic [FW-1:0] high_run;
    logic          seen, done;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            width_cnt <= '0;
            high_run  <= '0;
            seen      <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (pulse_out && width_cnt != PW'(PULSE_CYCLES + 1))
                width_cnt <= width_cnt + 1'b1;
            if (!loop_sync)
                high_run <= '0;
            else if (high_run != FW'(FILT_CYCLES + 1))
                high_run <= high_run + 1'b1;
            seen <= seen | pulse_out;
            done <= done | (seen & ~pulse_out);
        end
    end

    // R1
    always @(negedge clk) begin
        if (!por_n) begin
            por_clear_chk: assert (!pulse_out && !chip_rst);
        end
    end

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pulse_out) |-> width_cnt == PW'(PULSE_CYCLES));

    // R3
    one_shot_chk: assert property (@(posedge clk) disable iff (!por_n)
        done |-> !pulse_out);

    // R6
    qualify_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_rst) |-> high_run >= FW'(FILT_CYCLES));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!por_n)
        (chip_rst && !loop_sync) |=> !chip_rst);

endmodule

bind prst_top prst_chk #(
    .FILT_CYCLES (FILT_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .pulse_out(pulse_out),
    .chip_rst (chip_rst),
    .loop_sync(loop_sync)
);

// File: tb/sim_prst_top.sv
`timescale 1ns/1ps
module sim_prst_top;
    localparam int CLK_PS  = 20000;
    localparam int PLS_NS  = 4000;
    localparam int GLT_PS  = 30000;
    localparam int PULSE   = (PLS_NS * 1000) / CLK_PS;   // 200
    localparam int FILT    = GLT_PS / CLK_PS + 2;        // 3
    localparam int NVEC    = 7;
    // stimulus: high stretch in sampling edges; expected chip_rst width
    localparam int VK [NVEC] = '{1, 2, 3, 4, 7, 12, 2};
    localparam int VW [NVEC] = '{0, 0, 1, 2, 5, 10, 0};

    logic clk = 1'b0;
    logic por_n, short_en, drv;
    wire  loop_in;
    logic pulse_out, chip_rst;
    int   checks = 0, fails = 0;

    assign loop_in = short_en ? pulse_out : drv;

    prst_top #(.CLK_PERIOD_PS(CLK_PS), .PULSE_NS(PLS_NS), .GLITCH_PS(GLT_PS)) u0 (
        .clk(clk), .por_n(por_n), .loop_in(loop_in),
        .pulse_out(pulse_out), .chip_rst(chip_rst)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // release por_n and observe a window; indices count samples after edge 1
    task automatic run_pulse(input int win, output int p_first, output int p_cnt,
                             output int r_first, output int r_cnt);
        p_first = -1; r_first = -1; p_cnt = 0; r_cnt = 0;
        @(negedge clk); por_n = 1'b1;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pulse_out) begin p_cnt++; if (p_first < 0) p_first = i; end
            if (chip_rst)  begin r_cnt++; if (r_first < 0) r_first = i; end
        end
    endtask

    task automatic por_low(input int cyc);
        @(negedge clk); por_n = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int pf, pc, rf, rc, rfirst, rcnt, idle_hi;
        por_n = 1'b1; short_en = 1'b1; drv = 1'b0;
        #1 por_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 pulse_out in reset", int'(pulse_out), 0);
        chk("R1 chip_rst in reset", int'(chip_rst), 0);

        // shorted loop
        run_pulse(PULSE + 20, pf, pc, rf, rc);
        chk("R2 pulse start", pf, 0);
        chk("R2 pulse width", pc, PULSE);
        chk("R4 chip_rst latency", rf - pf, 2 + FILT);
        chk("R7 chip_rst width shorted", rc, PULSE - FILT + 1);

        // R3: no retrigger
        idle_hi = 0;
        for (int i = 0; i < 2 * PULSE; i++) begin
            @(negedge clk);
            if (pulse_out) idle_hi++;
        end
        chk("R3 no retrigger", idle_hi, 0);

        // vector table on the filter
        short_en = 1'b0; drv = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            repeat (8) @(negedge clk);
            rfirst = -1; rcnt = 0;
            drv = 1'b1;
            for (int j = 0; j < VK[v] + FILT + 8; j++) begin
                @(negedge clk);
                if (chip_rst) begin rcnt++; if (rfirst < 0) rfirst = j; end
                if (j == VK[v] - 1) drv = 1'b0;
            end
            if (VW[v] == 0) chk("R6 glitch rejected", rcnt, 0);
            else begin
                chk("R7 qualified width", rcnt, VW[v]);
                chk("R4 qualified rise", rfirst, 1 + FILT);
                chk("R5 release edge", rfirst + rcnt, VK[v] + 2);
            end
        end

        // R8 open loop
        drv = 1'b0; short_en = 1'b0;
        por_low(3);
        run_pulse(PULSE + 20, pf, pc, rf, rc);
        chk("R8 pulse still generated", pc, PULSE);
        chk("R8 chip_rst stays low", rc, 0);

        // R1 async clear mid-pulse, R9 re-arm
        short_en = 1'b1;
        por_low(3);
        run_pulse(50, pf, pc, rf, rc);
        chk("R9 pulse running before cut", int'(pulse_out), 1);
        #3 por_n = 1'b0;
        #1;
        chk("R1 async clear pulse_out", int'(pulse_out), 0);
        chk("R1 async clear chip_rst", int'(chip_rst), 0);
        repeat (3) @(negedge clk);
        run_pulse(PULSE + 20, pf, pc, rf, rc);
        chk("R9 full pulse after re-arm", pc, PULSE);
        chk("R9 chip_rst after re-arm", rc, PULSE - FILT + 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule